// File: doc/BRIEF.md
# Queue Pointer Controller

This block keeps a read pointer and a write pointer for each of a set of hardware ring queues. The queues are shared between a host and on-chip agents. The host never writes a pointer value directly. It advances a pointer by writing an increment to that queue's add register, and it reads the current pointer values from two status words. Each pointer wraps modulo the queue's size. The size is a power of two that the host selects through a per-queue size register. When an advance would overrun the other pointer, the block raises a sticky error flag. The flag sits in the upper bits of both status words.

The host side is a plain 32-bit register slave with an address, a write enable, write data and read data. A write takes effect on the clock edge where `bus_we` is high. A read has no enable. The word at `bus_addr` is registered on every clock edge and appears on `bus_rdata` one cycle later. This is a register port and not a stream, so it has no valid/ready handshake and no back-pressure. Every access completes in a single cycle. The block covers only pointer storage, the add operations, status readback and address decoding.

Top module: `qptr_ctrl`

## Requirements
- R1: Address decoding works as follows. The queue space is selected when `bus_addr[19]` is 1. The queue index is `bus_addr[18:11]`, so each queue has a 0x800-byte window. The register offset is `bus_addr[10:0]`. An address is unmapped if bit 19 is 0, the index is at or above `NUM_Q`, or the offset is not 0x0, 0x4, 0x8, 0xC or 0x10. Writes to unmapped addresses are ignored. Reads of unmapped addresses and of the write-only offsets 0x0 and 0x4 return 0.
- R2: A write to offset 0x4 adds the clamped increment to that queue's write pointer, modulo the queue size.
- R3: A write to offset 0x0 adds the clamped increment to that queue's read pointer, modulo the queue size.
- R4: The increment is the written value, clamped to 63. Any value above 63, including the full 32-bit range, advances the pointer by exactly 63.
- R5: A read of offset 0x8 returns the read pointer in bits [17:0]. A read of offset 0xC returns the write pointer in bits [17:0]. Both words carry the overflow flag in bit 31 and the underflow flag in bit 30, and bits [29:18] are 0. Data appears on `bus_rdata` at the clock edge after the address is presented.
- R6: A write to offset 0x10 sets the size code k to the written value, clamped to 10. The queue size becomes 256 << k. The same write clears that queue's pointers and flags. A read of 0x10 returns k in bits [3:0].
- R7: The overflow flag is set when a write-pointer add makes the occupancy plus the increment reach or exceed the size. Occupancy is (write − read) mod size. Once set, the flag stays set until a size write or a reset.
- R8: The underflow flag is set when a read-pointer add has an increment larger than the occupancy. Once set, the flag stays set until a size write or a reset.
- R9: Reset clears every pointer, every flag and every size code (size 256), and drives `bus_rdata` to 0.
- R10: An operation on one queue leaves the pointers, flags and size of every other queue unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 20 | Byte address of the access |
| bus_we | input | 1 | Write strobe, one write per high cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |

## Verification
Pointer wrap at the largest size (2^18 entries) is the hardest case to reach from the ports. Each add moves a pointer by at most 63, so crossing the end takes thousands of writes. The bench selects the largest size on one queue and issues more than 4,100 maximal adds. It checks that the pointer comes back to the small arithmetic remainder and that overflow is raised on the way. An address with bit 19 clear that would otherwise alias queue 0 is also exercised, and queue 0's status is read back afterwards to show that nothing moved.

// File: rtl/qpc_pkg.sv
package qpc_pkg;
  localparam int ADDR_W   = 20;
  localparam int DATA_W   = 32;
  localparam int PTR_W    = 18;
  localparam int CODE_W   = 4;
  localparam int QIDX_W   = 8;
  localparam int OFF_W    = 11;
  localparam int MIN_LOG  = 8;
  localparam int MAX_CODE = 10;
  localparam int MAX_INC  = 63;
  localparam int INC_W    = 6;
  localparam int OVF_BIT  = 31;
  localparam int UNF_BIT  = 30;

  localparam logic [OFF_W-1:0] OFF_ADD_RD = 11'h000;
  localparam logic [OFF_W-1:0] OFF_ADD_WR = 11'h004;
  localparam logic [OFF_W-1:0] OFF_STS_RD = 11'h008;
  localparam logic [OFF_W-1:0] OFF_STS_WR = 11'h00C;
  localparam logic [OFF_W-1:0] OFF_SIZE   = 11'h010;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ADD_RD,
    SEL_ADD_WR,
    SEL_STS_RD,
    SEL_STS_WR,
    SEL_SIZE
  } reg_sel_e;
endpackage

// File: rtl/qpc_decode.sv
module qpc_decode
  import qpc_pkg::*;
#(
  parameter int NUM_Q = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [QIDX_W-1:0] qidx,
  output reg_sel_e          sel,
  output logic              hit
);
  logic [OFF_W-1:0] off;
  logic             in_space;
  logic             q_ok;

  assign off      = addr[OFF_W-1:0];
  assign qidx     = addr[OFF_W+QIDX_W-1:OFF_W];
  assign in_space = addr[ADDR_W-1];
  assign q_ok     = (32'(qidx) < NUM_Q);

  always_comb begin
    sel = SEL_NONE;
    if (in_space && q_ok) begin
      case (off)
        OFF_ADD_RD: sel = SEL_ADD_RD;
        OFF_ADD_WR: sel = SEL_ADD_WR;
        OFF_STS_RD: sel = SEL_STS_RD;
        OFF_STS_WR: sel = SEL_STS_WR;
        OFF_SIZE:   sel = SEL_SIZE;
        default:    sel = SEL_NONE;
      endcase
    end
  end

  assign hit = (sel != SEL_NONE);
endmodule

// File: rtl/qpc_clamp.sv
module qpc_clamp
  import qpc_pkg::*;
(
  input  logic [DATA_W-1:0] wdata,
  output logic [INC_W-1:0]  inc,
  output logic [CODE_W-1:0] code
);
  always_comb begin
    if (wdata > DATA_W'(MAX_INC)) inc = INC_W'(MAX_INC);
    else                          inc = wdata[INC_W-1:0];
    if (wdata > DATA_W'(MAX_CODE)) code = CODE_W'(MAX_CODE);
    else                           code = wdata[CODE_W-1:0];
  end
endmodule

// File: rtl/qpc_slot.sv
module qpc_slot
  import qpc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              add_rd,
  input  logic              add_wr,
  input  logic              set_size,
  input  logic [INC_W-1:0]  inc,
  input  logic [CODE_W-1:0] new_code,
  output logic [PTR_W-1:0]  rd_ptr,
  output logic [PTR_W-1:0]  wr_ptr,
  output logic              ovf,
  output logic              unf,
  output logic [CODE_W-1:0] code
);
  logic [PTR_W-1:0] mask;
  logic [PTR_W-1:0] occ;
  logic [PTR_W:0]   occ_plus;
  logic             ovf_hit;
  logic             unf_hit;

  assign mask     = PTR_W'((32'd1 << (MIN_LOG + 32'(code))) - 32'd1);
  assign occ      = (wr_ptr - rd_ptr) & mask;
  assign occ_plus = {1'b0, occ} + (PTR_W+1)'(inc);
  assign ovf_hit  = occ_plus > {1'b0, mask};
  assign unf_hit  = PTR_W'(inc) > occ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      ovf    <= 1'b0;
      unf    <= 1'b0;
      code   <= '0;
    end else if (set_size) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      ovf    <= 1'b0;
      unf    <= 1'b0;
      code   <= new_code;
    end else begin
      if (add_wr) begin
        wr_ptr <= (wr_ptr + PTR_W'(inc)) & mask;
        if (ovf_hit) ovf <= 1'b1;
      end
      if (add_rd) begin
        rd_ptr <= (rd_ptr + PTR_W'(inc)) & mask;
        if (unf_hit) unf <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/qpc_rdmux.sv
module qpc_rdmux
  import qpc_pkg::*;
#(
  parameter int NUM_Q = 8
) (
  input  logic [QIDX_W-1:0]             qidx,
  input  reg_sel_e                      sel,
  input  logic [NUM_Q-1:0][PTR_W-1:0]   rd_ptr,
  input  logic [NUM_Q-1:0][PTR_W-1:0]   wr_ptr,
  input  logic [NUM_Q-1:0]              ovf,
  input  logic [NUM_Q-1:0]              unf,
  input  logic [NUM_Q-1:0][CODE_W-1:0]  code,
  output logic [DATA_W-1:0]             word
);
  localparam int SEL_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1;

  logic [SEL_W-1:0]  q;
  logic [DATA_W-1:0] flags;

  assign q = SEL_W'(qidx);

  always_comb begin
    flags = '0;
    flags[OVF_BIT] = ovf[q];
    flags[UNF_BIT] = unf[q];
    case (sel)
      SEL_STS_RD: word = flags | DATA_W'(rd_ptr[q]);
      SEL_STS_WR: word = flags | DATA_W'(wr_ptr[q]);
      SEL_SIZE:   word = DATA_W'(code[q]);
      default:    word = '0;
    endcase
  end
endmodule

// File: rtl/qptr_ctrl.sv
module qptr_ctrl
  import qpc_pkg::*;
#(
  parameter int NUM_Q = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [19:0]       bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata
);
  logic [QIDX_W-1:0]            qidx;
  reg_sel_e                     sel;
  logic                         hit;
  logic [INC_W-1:0]             inc;
  logic [CODE_W-1:0]            new_code;
  logic [NUM_Q-1:0][PTR_W-1:0]  rd_ptr_q;
  logic [NUM_Q-1:0][PTR_W-1:0]  wr_ptr_q;
  logic [NUM_Q-1:0]             ovf_q;
  logic [NUM_Q-1:0]             unf_q;
  logic [NUM_Q-1:0][CODE_W-1:0] size_code_q;
  logic [DATA_W-1:0]            rd_word;

  qpc_decode #(.NUM_Q(NUM_Q)) u_dec (
    .addr (bus_addr),
    .qidx (qidx),
    .sel  (sel),
    .hit  (hit)
  );

  qpc_clamp u_clamp (
    .wdata (bus_wdata),
    .inc   (inc),
    .code  (new_code)
  );

  for (genvar g = 0; g < NUM_Q; g++) begin : g_slot
    logic mine;
    assign mine = bus_we && hit && (32'(qidx) == g);

    qpc_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .add_rd   (mine && (sel == SEL_ADD_RD)),
      .add_wr   (mine && (sel == SEL_ADD_WR)),
      .set_size (mine && (sel == SEL_SIZE)),
      .inc      (inc),
      .new_code (new_code),
      .rd_ptr   (rd_ptr_q[g]),
      .wr_ptr   (wr_ptr_q[g]),
      .ovf      (ovf_q[g]),
      .unf      (unf_q[g]),
      .code     (size_code_q[g])
    );
  end

  qpc_rdmux #(.NUM_Q(NUM_Q)) u_mux (
    .qidx   (qidx),
    .sel    (sel),
    .rd_ptr (rd_ptr_q),
    .wr_ptr (wr_ptr_q),
    .ovf    (ovf_q),
    .unf    (unf_q),
    .code   (size_code_q),
    .word   (rd_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= rd_word;
  end
endmodule

// File: rtl/qpc_checker.sv
module qpc_checker
  import qpc_pkg::*;
#(
  parameter int NUM_Q = 8
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [19:0]                  bus_addr,
  input logic                         bus_we,
  input logic [31:0]                  bus_rdata,
  input logic [NUM_Q-1:0][PTR_W-1:0]  rd_ptr_q,
  input logic [NUM_Q-1:0][PTR_W-1:0]  wr_ptr_q,
  input logic [NUM_Q-1:0]             ovf_q,
  input logic [NUM_Q-1:0][CODE_W-1:0] size_code_q
);
  p_unmapped_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_addr[19] |=> bus_rdata == 32'd0);

  p_reset_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (bus_rdata == 32'd0) && (ovf_q == '0));

  for (genvar g = 0; g < NUM_Q; g++) begin : g_q
    logic [PTR_W-1:0]  mask;
    logic [ADDR_W-1:0] size_addr;
    logic [ADDR_W-1:0] addwr_addr;
    assign mask       = PTR_W'((32'd1 << (MIN_LOG + 32'(size_code_q[g]))) - 32'd1);
    assign size_addr  = {1'b1, QIDX_W'(g), OFF_SIZE};
    assign addwr_addr = {1'b1, QIDX_W'(g), OFF_ADD_WR};

    p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_we |=> $stable(rd_ptr_q[g]) && $stable(wr_ptr_q[g]));

    p_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((rd_ptr_q[g] & ~mask) == '0) && ((wr_ptr_q[g] & ~mask) == '0));

    p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_q[g] && !(bus_we && bus_addr == size_addr) |=> ovf_q[g]);

    p_inc_capped_r4: assert property (@(posedge clk) disable iff (!rst_n)
      bus_we && bus_addr == addwr_addr |=>
        ((wr_ptr_q[g] - $past(wr_ptr_q[g])) & mask) <= PTR_W'(MAX_INC));
  end
endmodule

bind qptr_ctrl qpc_checker #(.NUM_Q(NUM_Q)) u_qpc_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_addr    (bus_addr),
  .bus_we      (bus_we),
  .bus_rdata   (bus_rdata),
  .rd_ptr_q    (rd_ptr_q),
  .wr_ptr_q    (wr_ptr_q),
  .ovf_q       (ovf_q),
  .size_code_q (size_code_q)
);

// File: tb/test_qptr_ctrl.sv
module test_qptr_ctrl;
  localparam int NQ = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int compared = 0;
  int mismatched = 0;

  int m_rd [NQ];
  int m_wr [NQ];
  int m_k  [NQ];
  bit m_ovf[NQ];
  bit m_unf[NQ];

  always #5 clk = ~clk;

  qptr_ctrl #(.NUM_Q(NQ)) i_qptr_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata)
  );

  function automatic logic [19:0] at(int q, int off);
    return 20'h80000 | 20'(q << 11) | 20'(off);
  endfunction

  function automatic int clampv(logic [31:0] v);
    return (v > 32'd63) ? 63 : int'(v);
  endfunction

  function automatic logic [31:0] sts(int q, bit wr_side);
    logic [31:0] w;
    w = 32'(wr_side ? m_wr[q] : m_rd[q]);
    w[31] = m_ovf[q];
    w[30] = m_unf[q];
    return w;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(logic [19:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic read_chk(logic [19:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(posedge clk);
    #1;
    check(tag, bus_rdata, exp);
  endtask

  task automatic add_wr(int q, logic [31:0] v);
    int size, inc, occ;
    size = 256 << m_k[q];
    inc  = clampv(v);
    occ  = (m_wr[q] - m_rd[q] + size) % size;
    if (occ + inc >= size) m_ovf[q] = 1'b1;
    m_wr[q] = (m_wr[q] + inc) % size;
    bus_write(at(q, 'h4), v);
  endtask

  task automatic add_rd(int q, logic [31:0] v);
    int size, inc, occ;
    size = 256 << m_k[q];
    inc  = clampv(v);
    occ  = (m_wr[q] - m_rd[q] + size) % size;
    if (inc > occ) m_unf[q] = 1'b1;
    m_rd[q] = (m_rd[q] + inc) % size;
    bus_write(at(q, 'h0), v);
  endtask

  task automatic set_size(int q, logic [31:0] v);
    m_k[q] = (v > 32'd10) ? 10 : int'(v);
    m_rd[q] = 0; m_wr[q] = 0; m_ovf[q] = 0; m_unf[q] = 0;
    bus_write(at(q, 'h10), v);
  endtask

  task automatic check_all(string tag);
    for (int q = 0; q < NQ; q++) begin
      read_chk(at(q, 'h8), sts(q, 0), tag);
      read_chk(at(q, 'hC), sts(q, 1), tag);
      read_chk(at(q, 'h10), 32'(m_k[q]), tag);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [31:0] incs [9];
    incs = '{32'd0, 32'd1, 32'd2, 32'd31, 32'd62, 32'd63, 32'd64, 32'd100, 32'hFFFF_FFFF};
    for (int q = 0; q < NQ; q++) begin
      m_rd[q] = 0; m_wr[q] = 0; m_k[q] = 0; m_ovf[q] = 0; m_unf[q] = 0;
    end
    repeat (3) @(negedge clk);
    #1 check("R9 rdata in reset", bus_rdata, 32'd0);
    rst_n = 1'b1;
    check_all("R9 reset state");

    // R2 R4 R7: write adds across the increment set on each queue
    for (int q = 0; q < NQ; q++) begin
      for (int i = 0; i < 9; i++) begin
        add_wr(q, incs[(i + q) % 9]);
        read_chk(at(q, 'hC), sts(q, 1), "R2 R4 R7 write add");
      end
      check_all("R10 isolation after write adds");
    end

    // R3 R8: read adds, pass the write pointer to raise underflow
    for (int q = 0; q < NQ; q++) begin
      for (int i = 0; i < 9; i++) begin
        add_rd(q, incs[(2 * i + q) % 9]);
        read_chk(at(q, 'h8), sts(q, 0), "R3 R8 read add");
      end
    end
    check_all("R5 R10 status after read adds");

    // R1: unmapped accesses
    read_chk(20'h00008, 32'd0, "R1 bit19 clear read");
    read_chk(at(NQ, 'h8), 32'd0, "R1 queue beyond range read");
    read_chk(at(0, 'h14), 32'd0, "R1 bad offset read");
    read_chk(at(0, 'h0), 32'd0, "R1 add reg reads zero");
    read_chk(at(0, 'h4), 32'd0, "R1 add reg reads zero");
    bus_write(20'h00004, 32'd5);
    bus_write(20'h00000, 32'd7);
    bus_write(at(NQ, 'h4), 32'd9);
    bus_write(at(255, 'h0), 32'd9);
    bus_write(at(0, 'h14), 32'd3);
    bus_write(20'h00010, 32'd4);
    check_all("R1 unmapped writes ignored");

    // R6: size codes, clamp, clearing
    set_size(1, 32'd2);
    check_all("R6 size code 2 clears queue");
    set_size(3, 32'd15);
    read_chk(at(3, 'h10), 32'd10, "R6 size code clamp");
    for (int i = 0; i < 20; i++) add_wr(1, 32'd63);
    read_chk(at(1, 'hC), sts(1, 1), "R6 wrap at 1024");
    for (int i = 0; i < 25; i++) add_rd(1, 32'd50);
    check_all("R6 R8 size 1024 read adds");

    // R6 R7: wrap at the largest size on queue 3
    for (int i = 0; i < 4162; i++) add_wr(3, 32'hFFFF_FFFF);
    read_chk(at(3, 'hC), sts(3, 1), "R6 R7 wrap at 2^18");
    check("R6 wrap remainder", 32'(m_wr[3]), 32'd62);
    check("R7 overflow expected", 32'(m_ovf[3]), 32'd1);
    check_all("R10 final state");

    // R9: reset again mid-run
    @(negedge clk);
    rst_n = 1'b0;
    for (int q = 0; q < NQ; q++) begin
      m_rd[q] = 0; m_wr[q] = 0; m_k[q] = 0; m_ovf[q] = 0; m_unf[q] = 0;
    end
    @(negedge clk);
    rst_n = 1'b1;
    check_all("R9 second reset");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule